// File: doc/BRIEF.md
# Microprogram Sequencer with Return Stack

This block replaces a large encoded state machine with a microcoded controller. A program counter addresses an initialised control ROM. Every ROM word carries two things: a set of control outputs for a datapath, and a next-address instruction that says where the counter goes next. The counter can step forward by one, branch on one selected status input (in either sense), jump, call a subroutine or return from one.

A small hardware stack keeps the return addresses for nested subroutine calls. A push onto a full stack and a pop from an empty stack are both caught in sticky error flags. The ROM image is given as a parameter. The datapath being controlled and any run-time loading of the ROM are not part of this block.

Each ROM word is 31 bits wide with the default parameters. From the top bit down it holds the next-address opcode in bits [30:28], the status select in bits [27:24], the destination address in bits [23:16] and the control outputs in bits [15:0]. Word `a` sits at bits `[a*31 +: 31]` of the ROM parameter.

Top module: `useq_core`

## Requirements
- R1: While reset is high and in the first cycle after it, the address is 0, the control outputs are 0, both error flags are 0 and the return stack is empty.
- R2: Opcodes 0, 6 and 7 (continue) move the address to the current address plus one.
- R3: Opcode 1 (branch if true) loads the destination field when the status input chosen by the select field is 1. Otherwise it advances by one.
- R4: Opcode 2 (branch if false) loads the destination field when the selected status input is 0. Otherwise it advances by one.
- R5: Opcode 3 (jump) always loads the destination field.
- R6: Opcode 4 (call) loads the destination field and pushes the current address plus one onto the return stack.
- R7: Opcode 5 (return) loads the most recently pushed address and pops it, so nested calls unwind in last-in, first-out order.
- R8: The control outputs are registered. In the cycle after the address is A, they equal bits [15:0] of ROM word A.
- R9: The stack holds 4 entries. A call made while 4 entries are held still jumps, but it discards its return address and sets the overflow flag, which stays set until reset.
- R10: A return made with an empty stack loads address 0 and sets the underflow flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | 16 | Status conditions; the select field picks one |
| upc_o | output | 8 | Current microprogram address |
| ctl_o | output | 16 | Registered control outputs of the previous address |
| stk_ovf_o | output | 1 | Sticky flag: a call was made with the stack full |
| stk_unf_o | output | 1 | Sticky flag: a return was made with the stack empty |

## Verification
A fixed microprogram is walked under four status patterns, and the bench compares the address trace and the control outputs cycle by cycle.
- The first pattern leaves every branch untaken and then follows a jump into two nested calls. This separates stepping, jumping and the order in which returns unwind.
- The second pattern holds a status bit high so that one word loops on itself. It then drops the bit, which shows that the branch follows the status from one cycle to the next, and it exercises the false-sense branch in its taken direction.
- The last two patterns send the program into a chain of five calls and into a return with nothing pushed. Overflow shows that the fifth return address was dropped, not written over the top entry. Underflow shows the jump back to address 0 and that both flags stay set.

// File: rtl/useq_core.sv
module useq_core #(
  parameter int AW    = 8,
  parameter int CSW   = 4,
  parameter int OW    = 16,
  parameter int DEPTH = 4,
  parameter logic [(2**AW)*(3+CSW+AW+OW)-1:0] UCODE = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [(2**CSW)-1:0] status_i,
  output logic [AW-1:0]       upc_o,
  output logic [OW-1:0]       ctl_o,
  output logic                stk_ovf_o,
  output logic                stk_unf_o
);
  localparam int WW  = 3 + CSW + AW + OW;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  localparam logic [2:0] OP_BT   = 3'd1;
  localparam logic [2:0] OP_BF   = 3'd2;
  localparam logic [2:0] OP_JMP  = 3'd3;
  localparam logic [2:0] OP_CALL = 3'd4;
  localparam logic [2:0] OP_RET  = 3'd5;

  logic [AW-1:0]  pc_q, pc_nx, pc_inc, top;
  logic [WW-1:0]  word;
  logic [2:0]     op;
  logic [CSW-1:0] csel;
  logic [AW-1:0]  dest;
  logic           cond, full, empty, push, pop;
  logic [SPW-1:0] sp_q;
  logic [AW-1:0]  stk_q [DEPTH];
  logic [OW-1:0]  ctl_q;
  logic           ovf_q, unf_q;

  assign word   = UCODE[int'(pc_q)*WW +: WW];
  assign op     = word[WW-1 -: 3];
  assign csel   = word[OW+AW +: CSW];
  assign dest   = word[OW +: AW];
  assign cond   = status_i[csel];
  assign pc_inc = pc_q + 1'b1;
  assign full   = (sp_q == SPW'(DEPTH));
  assign empty  = (sp_q == '0);
  assign top    = empty ? '0 : stk_q[IW'(sp_q - 1'b1)];
  assign push   = (op == OP_CALL);
  assign pop    = (op == OP_RET);

  always_comb begin
    case (op)
      OP_BT:   pc_nx = cond ? dest : pc_inc;
      OP_BF:   pc_nx = cond ? pc_inc : dest;
      OP_JMP:  pc_nx = dest;
      OP_CALL: pc_nx = dest;
      OP_RET:  pc_nx = empty ? '0 : top;
      default: pc_nx = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      sp_q  <= '0;
      ctl_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      pc_q  <= pc_nx;
      ctl_q <= word[OW-1:0];
      if (push && !full) sp_q <= sp_q + 1'b1;
      if (pop && !empty) sp_q <= sp_q - 1'b1;
      if (push && full)  ovf_q <= 1'b1;
      if (pop && empty)  unf_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stk
    always_ff @(posedge clk)
      if (!rst && push && !full && sp_q == SPW'(i)) stk_q[i] <= pc_inc;
  end

  assign upc_o     = pc_q;
  assign ctl_o     = ctl_q;
  assign stk_ovf_o = ovf_q;
  assign stk_unf_o = unf_q;

  // R2
  cont_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0 || op == 3'd6 || op == 3'd7) |=> pc_q == $past(pc_q) + 1'b1);

  // R3
  bt_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BT && cond) |=> pc_q == $past(dest));

  // R6
  call_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (sp_q == $past(sp_q) + 1'b1 && top == $past(pc_inc)));

  // R7
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty) |=> (pc_q == $past(top) && sp_q == $past(sp_q) - 1'b1));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (stk_ovf_o && sp_q == SPW'(DEPTH)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stk_ovf_o |=> stk_ovf_o);

  // R10
  unf_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (pc_q == '0 && stk_unf_o));

  // R10
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stk_unf_o |=> stk_unf_o);

  // R9
  sp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SPW'(DEPTH));
endmodule

// File: tb/useq_core_tb.sv
`timescale 1ns/1ps
module useq_core_tb_top;
  localparam int WW = 31;

  function automatic logic [WW-1:0] uw(input logic [2:0] op, input logic [3:0] cs,
                                       input logic [7:0] dst, input logic [7:0] adr);
    return {op, cs, dst, 8'h5A, adr};
  endfunction

  function automatic logic [256*WW-1:0] build_prog();
    logic [256*WW-1:0] p;
    p = '0;
    p[8'h00*WW +: WW] = uw(3'd0, 4'd0, 8'h00, 8'h00);
    p[8'h01*WW +: WW] = uw(3'd1, 4'd3, 8'h01, 8'h01);
    p[8'h02*WW +: WW] = uw(3'd2, 4'd5, 8'h08, 8'h02);
    p[8'h03*WW +: WW] = uw(3'd1, 4'd7, 8'h50, 8'h03);
    p[8'h04*WW +: WW] = uw(3'd1, 4'd8, 8'h60, 8'h04);
    p[8'h05*WW +: WW] = uw(3'd3, 4'd0, 8'h20, 8'h05);
    p[8'h08*WW +: WW] = uw(3'd3, 4'd0, 8'h20, 8'h08);
    p[8'h20*WW +: WW] = uw(3'd4, 4'd0, 8'h30, 8'h20);
    p[8'h21*WW +: WW] = uw(3'd3, 4'd0, 8'h21, 8'h21);
    p[8'h30*WW +: WW] = uw(3'd4, 4'd0, 8'h40, 8'h30);
    p[8'h31*WW +: WW] = uw(3'd5, 4'd0, 8'h00, 8'h31);
    p[8'h40*WW +: WW] = uw(3'd6, 4'd0, 8'h00, 8'h40);
    p[8'h41*WW +: WW] = uw(3'd5, 4'd0, 8'h00, 8'h41);
    for (int a = 8'h50; a < 8'h55; a++)
      p[a*WW +: WW] = uw(3'd4, 4'd0, 8'(a + 1), 8'(a));
    p[8'h55*WW +: WW] = uw(3'd5, 4'd0, 8'h00, 8'h55);
    p[8'h60*WW +: WW] = uw(3'd7, 4'd0, 8'h00, 8'h60);
    p[8'h61*WW +: WW] = uw(3'd5, 4'd0, 8'h00, 8'h61);
    return p;
  endfunction

  localparam logic [256*WW-1:0] PROG = build_prog();

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] status = '0;
  logic [7:0]  upc;
  logic [15:0] ctl;
  logic        ovf, unf;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  useq_core #(.UCODE(PROG)) dut_i (
    .clk(clk), .rst(rst), .status_i(status),
    .upc_o(upc), .ctl_o(ctl), .stk_ovf_o(ovf), .stk_unf_o(unf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 pc in reset", upc, 0);
    chk("R1 ctl in reset", ctl, 0);
    chk("R1 flags in reset", {ovf, unf}, 0);
    rst = 1'b0;
  endtask

  task automatic step(input string tag, input logic [7:0] exp);
    chk(tag, upc, exp);
    @(posedge clk); @(negedge clk);
    chk("R8 ctl follows word", ctl, {8'h5A, exp});
  endtask

  task automatic t_main();
    status = 16'h0020;
    do_reset();
    step("R2 continue", 8'h00);
    step("R3 bt untaken", 8'h01);
    step("R4 bf untaken", 8'h02);
    step("R3 bt untaken s7", 8'h03);
    step("R3 bt untaken s8", 8'h04);
    step("R5 jump", 8'h05);
    step("R5 jump target", 8'h20);
    step("R6 call outer", 8'h30);
    step("R6 call inner", 8'h40);
    step("R2 op6 continue", 8'h41);
    step("R7 inner return", 8'h31);
    step("R7 outer return", 8'h21);
    step("R5 self jump", 8'h21);
    chk("R9 no overflow", ovf, 0);
    chk("R10 no underflow", unf, 0);
  endtask

  task automatic t_loop();
    status = 16'h0008;
    do_reset();
    step("R2 continue", 8'h00);
    step("R3 bt taken", 8'h01);
    step("R3 bt loop", 8'h01);
    status = 16'h0000;
    step("R3 bt loop exit", 8'h01);
    step("R3 bt fallthrough", 8'h02);
    step("R4 bf taken", 8'h08);
    step("R5 jump", 8'h20);
  endtask

  task automatic t_overflow();
    status = 16'h00A0;
    do_reset();
    step("R2 continue", 8'h00);
    step("R3", 8'h01);
    step("R4", 8'h02);
    step("R3 bt taken", 8'h03);
    for (int a = 8'h50; a < 8'h54; a++) step("R6 call chain", 8'(a));
    chk("R9 ovf clear at depth 4", ovf, 0);
    step("R6 call at full", 8'h54);
    chk("R9 ovf set", ovf, 1);
    step("R9 jump despite full", 8'h55);
    step("R9 top kept", 8'h54);
    chk("R9 ovf sticky", ovf, 1);
    chk("R10 unf clear", unf, 0);
  endtask

  task automatic t_underflow();
    status = 16'h0120;
    do_reset();
    step("R2 continue", 8'h00);
    step("R3", 8'h01);
    step("R4", 8'h02);
    step("R3", 8'h03);
    step("R3 bt taken s8", 8'h04);
    step("R2 op7 continue", 8'h60);
    chk("R10 unf clear", unf, 0);
    step("R1 R10 empty return", 8'h61);
    chk("R10 unf set", unf, 1);
    step("R10 restart at 0", 8'h00);
    step("R10 running", 8'h01);
    chk("R10 unf sticky", unf, 1);
    chk("R9 ovf clear", ovf, 0);
  endtask

  initial begin
    @(negedge clk);
    t_main();
    t_loop();
    t_overflow();
    t_underflow();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule